// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This engine tests an attached single-port synchronous RAM with the March C- algorithm: six passes over every word, 10n memory operations for an n-word array. A one-cycle `start_i` pulse latches the run options and sets the sequence going. The engine drives address, enable, write-enable and write data to the RAM. It compares each read word against the value it expects, one cycle after the read is issued, which covers the RAM's read latency. When the run ends it raises `done_o`, and `fail_o` shows whether any read miscompared.

The data background is either solid (all zeros) or a checkerboard whose bit polarity flips with the address parity. A "0" in the algorithm means the background word for that address and a "1" means its complement. An optional retention pause of a programmable number of idle cycles follows each write-ending pass, before the next read pass begins. The first miscompare is logged with its address, pass index, read word and expected word. The run either stops there or carries on to the end, as chosen at start.

The sequencer is one state machine with six states:
- IDLE: the state after reset.
- WRITE and READ: issue one memory operation each.
- PAUSE: the retention wait.
- DRAIN: the cycle that compares the last read.
- DONE: the run has ended.

Transitions:
- IDLE/DONE→WRITE on start.
- WRITE→READ for the next address of a read-write pass, and at the end of a pass when no pause is set.
- WRITE→WRITE for the next address of the initial pass.
- WRITE→PAUSE at the end of a pass when a pause is set.
- PAUSE→READ when the wait expires.
- READ→WRITE in passes 1 to 4.
- READ→READ for the next address of the final pass.
- READ→DRAIN after its last address.
- DRAIN→DONE.
- Any running state→DONE on a miscompare in stop mode.

Top module: `march_cm_engine`

## Requirements
- R1: A `start_i` pulse while idle or done begins a run: `fail_o` and the log clear, and the first operation, in the next cycle, is a write to address 0.
- R2: The passes run in this order, with these directions:
  - pass 0: ascending, w0.
  - pass 1: ascending, r0 then w1 at the same address.
  - pass 2: ascending, r1 then w0.
  - pass 3: descending, r0 then w1.
  - pass 4: descending, r1 then w0.
  - pass 5: ascending, r0.

  With stop mode off, this is exactly 10n enabled memory cycles, one operation per cycle.
- R3: With `bg_sel_i`=0 (solid), the value 0 is the all-zero word and the value 1 is the all-one word.
- R4: With `bg_sel_i`=1 (checkerboard), the value 0 has bit i set for odd i at even addresses (0xAA for 8 bits) and is inverted at odd addresses (0x55). The value 1 is the complement of the value 0.
- R5: Read data is compared with the expected word in the cycle after the read is issued.
- R6: The first miscompare of a run is logged with its address, pass index (0 to 5), read word and expected word. Later miscompares do not change the log.
- R7: `fail_o` stays high from the first miscompare until the next start.
- R8: With `stop_on_fail_i`=1, a miscompare ends the run. The operation of the cycle that detects it is the last one, and in the next cycle `done_o` is 1 and `mem_en_o` is 0.
- R9: With `stop_on_fail_i`=0, every operation of the algorithm is issued despite miscompares.
- R10: With `pause_len_i`=P>0, exactly P idle cycles (enable low, address held) follow each of passes 0 to 4 before the next pass's first read. With P=0 there are none.
- R11: `done_o` rises only after the final read has been compared (or on a stop). It stays high until the next start and is low after reset. `start_i` during a run has no effect.
- R12: `bg_sel_i`, `stop_on_fail_i` and `pause_len_i` are sampled only at start. Changes during a run do not alter the operation sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| bg_sel_i | input | 1 | Background: 0 solid, 1 checkerboard |
| stop_on_fail_i | input | 1 | 1 ends the run at the first miscompare |
| pause_len_i | input | PAUSE_W | Retention pause length in cycles |
| mem_en_o | output | 1 | Memory operation enable |
| mem_we_o | output | 1 | Write enable (read when 0 with enable) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data (carries the compare word during reads) |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the read |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Sticky miscompare flag |
| log_addr_o | output | ADDR_W | Address of the first miscompare |
| log_elem_o | output | 3 | Pass index of the first miscompare |
| log_rdata_o | output | DATA_W | Word read at the first miscompare |
| log_exp_o | output | DATA_W | Word expected at the first miscompare |

## Verification
The assertions check these rules on every cycle:
- the address counter steps by one in its direction;
- each read in passes 1 to 4 is followed by a complementing write to the same address;
- the address holds during a pause;
- the run opens with a write to address 0;
- a stop ends the run on the next cycle;
- the fail flag and log stay frozen once set.

Only the bench scenarios can show the rest:
- the full pass order and the 10n count;
- the exact checkerboard words;
- where pauses fall;
- which miscompare gets logged for a given stuck bit;
- that start and option changes mid-run are ignored.

These are checked against an independently built operation list and a faulty RAM model.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int unsigned ELEM_W    = 3;
    localparam logic [ELEM_W-1:0] LAST_ELEM = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_PAUSE,
        ST_DRAIN,
        ST_DONE
    } mce_state_e;

    // passes 3 and 4 walk the array from the top down
    function automatic logic elem_descending(input logic [ELEM_W-1:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    function automatic logic elem_reads(input logic [ELEM_W-1:0] e);
        return (e != 3'd0);
    endfunction

    function automatic logic elem_writes(input logic [ELEM_W-1:0] e);
        return (e != LAST_ELEM);
    endfunction

    // value expected by the read of a pass (0 = background, 1 = complement)
    function automatic logic elem_read_val(input logic [ELEM_W-1:0] e);
        return (e == 3'd2) || (e == 3'd4);
    endfunction

    // value stored by the write of a pass
    function automatic logic elem_write_val(input logic [ELEM_W-1:0] e);
        return (e == 3'd1) || (e == 3'd3);
    endfunction

endpackage

// File: rtl/mce_addr_gen.sv
module mce_addr_gen #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              init_down_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [ADDR_W-1:0] addr_q;
    logic              down_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else if (init_i) begin
            addr_q <= init_down_i ? TOP_ADDR : '0;
            down_q <= init_down_i;
        end else if (step_i) begin
            addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = down_q ? (addr_q == '0) : (addr_q == TOP_ADDR);

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i && !down_q) |=> (addr_o == $past(addr_o) + 1'b1));

    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i && down_q) |=> (addr_o == $past(addr_o) - 1'b1));

endmodule

// File: rtl/mce_bg_gen.sv
module mce_bg_gen #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              checker_i,
    input  logic              addr_lsb_i,
    input  logic              invert_i,
    output logic [DATA_W-1:0] word_o
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic ODD_BIT = ((i % 2) == 1);
        assign word_o[i] = invert_i ^ (checker_i & (ODD_BIT ^ addr_lsb_i));
    end

endmodule

// File: rtl/mce_fail_log.sv
module mce_fail_log #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       issue_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [mce_pkg::ELEM_W-1:0] elem_i,
    input  logic [DATA_W-1:0]          exp_i,
    input  logic [DATA_W-1:0]          rdata_i,
    output logic                       mismatch_o,
    output logic                       fail_o,
    output logic [ADDR_W-1:0]          log_addr_o,
    output logic [mce_pkg::ELEM_W-1:0] log_elem_o,
    output logic [DATA_W-1:0]          log_rdata_o,
    output logic [DATA_W-1:0]          log_exp_o
);

    logic                       pend_q;
    logic [ADDR_W-1:0]          pend_addr_q;
    logic [mce_pkg::ELEM_W-1:0] pend_elem_q;
    logic [DATA_W-1:0]          pend_exp_q;

    assign mismatch_o = pend_q && (rdata_i != pend_exp_q);

    // read issued this cycle is compared next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_elem_q <= '0;
            pend_exp_q  <= '0;
        end else begin
            pend_q <= issue_i;
            if (issue_i) begin
                pend_addr_q <= addr_i;
                pend_elem_q <= elem_i;
                pend_exp_q  <= exp_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fail_o      <= 1'b0;
            log_addr_o  <= '0;
            log_elem_o  <= '0;
            log_rdata_o <= '0;
            log_exp_o   <= '0;
        end else if (mismatch_o && !fail_o) begin
            fail_o      <= 1'b1;
            log_addr_o  <= pend_addr_q;
            log_elem_o  <= pend_elem_q;
            log_rdata_o <= rdata_i;
            log_exp_o   <= pend_exp_q;
        end
    end

    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clear_i) |=> fail_o);

    a_r6_log_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clear_i) |=> ($stable(log_addr_o) && $stable(log_elem_o)
                                  && $stable(log_rdata_o) && $stable(log_exp_o)));

    a_r5_compare_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> $past(issue_i));

endmodule

// File: rtl/march_cm_engine.sv
module march_cm_engine #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned PAUSE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       bg_sel_i,
    input  logic                       stop_on_fail_i,
    input  logic [PAUSE_W-1:0]         pause_len_i,
    output logic                       mem_en_o,
    output logic                       mem_we_o,
    output logic [ADDR_W-1:0]          mem_addr_o,
    output logic [DATA_W-1:0]          mem_wdata_o,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    output logic                       done_o,
    output logic                       fail_o,
    output logic [ADDR_W-1:0]          log_addr_o,
    output logic [mce_pkg::ELEM_W-1:0] log_elem_o,
    output logic [DATA_W-1:0]          log_rdata_o,
    output logic [DATA_W-1:0]          log_exp_o
);

    import mce_pkg::*;

    mce_state_e          state_q, state_d;
    logic [ELEM_W-1:0]   elem_q, elem_d;
    logic [PAUSE_W-1:0]  pcnt_q, pcnt_d;
    logic [PAUSE_W-1:0]  pause_q;
    logic                checker_q;
    logic                stop_q;

    logic                run_start;
    logic                ag_init, ag_init_down, ag_step, ag_last;
    logic                issue_rd;
    logic                pat_val;
    logic                cmp_mismatch;
    logic [DATA_W-1:0]   pat_word;

    mce_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (ag_init),
        .init_down_i (ag_init_down),
        .step_i      (ag_step),
        .addr_o      (mem_addr_o),
        .last_o      (ag_last)
    );

    mce_bg_gen #(.DATA_W(DATA_W)) u_bg (
        .checker_i  (checker_q),
        .addr_lsb_i (mem_addr_o[0]),
        .invert_i   (pat_val),
        .word_o     (pat_word)
    );

    mce_fail_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (run_start),
        .issue_i     (issue_rd),
        .addr_i      (mem_addr_o),
        .elem_i      (elem_q),
        .exp_i       (pat_word),
        .rdata_i     (mem_rdata_i),
        .mismatch_o  (cmp_mismatch),
        .fail_o      (fail_o),
        .log_addr_o  (log_addr_o),
        .log_elem_o  (log_elem_o),
        .log_rdata_o (log_rdata_o),
        .log_exp_o   (log_exp_o)
    );

    // next-state and sequencing
    always_comb begin
        state_d      = state_q;
        elem_d       = elem_q;
        pcnt_d       = pcnt_q;
        run_start    = 1'b0;
        ag_init      = 1'b0;
        ag_init_down = 1'b0;
        ag_step      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    run_start    = 1'b1;
                    elem_d       = '0;
                    ag_init      = 1'b1;
                    ag_init_down = elem_descending(3'd0);
                    state_d      = ST_WRITE;
                end
            end
            ST_READ: begin
                if (elem_writes(elem_q)) begin
                    state_d = ST_WRITE;
                end else if (ag_last) begin
                    state_d = ST_DRAIN;
                end else begin
                    ag_step = 1'b1;
                end
            end
            ST_WRITE: begin
                if (!ag_last) begin
                    ag_step = 1'b1;
                    state_d = elem_reads(elem_q) ? ST_READ : ST_WRITE;
                end else begin
                    elem_d       = elem_q + 3'd1;
                    ag_init      = 1'b1;
                    ag_init_down = elem_descending(elem_q + 3'd1);
                    if (pause_q != '0) begin
                        pcnt_d  = pause_q - 1'b1;
                        state_d = ST_PAUSE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_PAUSE: begin
                if (pcnt_q == '0) begin
                    state_d = ST_READ;
                end else begin
                    pcnt_d = pcnt_q - 1'b1;
                end
            end
            ST_DRAIN: state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
        if (stop_q && cmp_mismatch && (state_q != ST_IDLE) && (state_q != ST_DONE)) begin
            state_d = ST_DONE;
            ag_step = 1'b0;
            ag_init = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            pcnt_q    <= '0;
            pause_q   <= '0;
            checker_q <= 1'b0;
            stop_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            elem_q  <= elem_d;
            pcnt_q  <= pcnt_d;
            if (run_start) begin
                pause_q   <= pause_len_i;
                checker_q <= bg_sel_i;
                stop_q    <= stop_on_fail_i;
            end
        end
    end

    // outputs
    always_comb begin
        mem_en_o = 1'b0;
        mem_we_o = 1'b0;
        done_o   = 1'b0;
        issue_rd = 1'b0;
        pat_val  = elem_write_val(elem_q);
        unique case (state_q)
            ST_WRITE: begin
                mem_en_o = 1'b1;
                mem_we_o = 1'b1;
            end
            ST_READ: begin
                mem_en_o = 1'b1;
                issue_rd = 1'b1;
                pat_val  = elem_read_val(elem_q);
            end
            ST_DONE: done_o = 1'b1;
            ST_IDLE, ST_PAUSE, ST_DRAIN: ;
            default: ;
        endcase
    end

    assign mem_wdata_o = pat_word;

    a_r1_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i)
        |=> (mem_en_o && mem_we_o && (mem_addr_o == '0)));

    a_r2_read_then_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && !mem_we_o && (elem_q != LAST_ELEM))
        |=> (mem_we_o && (mem_addr_o == $past(mem_addr_o))
             && (mem_wdata_o == ~$past(mem_wdata_o))));

    a_r10_pause_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |=> $stable(mem_addr_o));

    a_r8_stop_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && cmp_mismatch && mem_en_o) |=> (done_o && !mem_en_o));

    a_r11_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (($past(state_q) == ST_DRAIN) || $past(stop_q)));

endmodule

// File: tb/march_cm_engine_tb_top.sv
`timescale 1ns/1ps
module march_cm_engine_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          bg_sel_i = 1'b0;
    logic          stop_on_fail_i = 1'b0;
    logic [PW-1:0] pause_len_i = '0;
    logic          mem_en_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          done_o, fail_o;
    logic [AW-1:0] log_addr_o;
    logic [2:0]    log_elem_o;
    logic [DW-1:0] log_rdata_o, log_exp_o;

    always #2 clk = ~clk;

    march_cm_engine #(.ADDR_W(AW), .DATA_W(DW), .PAUSE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bg_sel_i(bg_sel_i),
        .stop_on_fail_i(stop_on_fail_i), .pause_len_i(pause_len_i),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .fail_o(fail_o), .log_addr_o(log_addr_o),
        .log_elem_o(log_elem_o), .log_rdata_o(log_rdata_o), .log_exp_o(log_exp_o)
    );

    int nchecks = 0;
    int nfails  = 0;

    // attached RAM with an optional stuck-bit fault
    logic [DW-1:0] ram [N];
    bit            flt_on = 0;
    int            flt_addr = 0;
    logic [DW-1:0] flt_mask = '0;
    logic [DW-1:0] flt_val = '0;

    function automatic logic [DW-1:0] faulty(int a, logic [DW-1:0] d);
        if (flt_on && a == flt_addr) return (d & ~flt_mask) | (flt_val & flt_mask);
        return d;
    endfunction

    always @(posedge clk) begin
        if (mem_en_o && mem_we_o) ram[mem_addr_o] <= faulty(int'(mem_addr_o), mem_wdata_o);
        if (mem_en_o && !mem_we_o) mem_rdata_i <= ram[mem_addr_o];
    end

    // requirement-level pass descriptions
    function automatic bit p_down(int e);   return e == 3 || e == 4; endfunction
    function automatic bit p_reads(int e);  return e != 0; endfunction
    function automatic bit p_writes(int e); return e != 5; endfunction
    function automatic bit p_rv(int e);     return e == 2 || e == 4; endfunction
    function automatic bit p_wv(int e);     return e == 1 || e == 3; endfunction

    function automatic logic [DW-1:0] pat(bit chk, int a, bit v);
        logic [DW-1:0] base;
        base = chk ? ((a % 2 == 1) ? 8'h55 : 8'hAA) : 8'h00;
        return v ? ~base : base;
    endfunction

    // expected per-cycle operation list
    int q_en[$], q_we[$], q_addr[$], q_wd[$];
    bit e_fail;
    int e_laddr, e_lelem, e_lrd, e_lexp;

    task automatic push_op(int en, int we, int a, int wd);
        q_en.push_back(en); q_we.push_back(we); q_addr.push_back(a); q_wd.push_back(wd);
    endtask

    task automatic build(bit chk, int pause, bit stop);
        logic [DW-1:0] ref_mem [N];
        int stop_idx;
        q_en.delete(); q_we.delete(); q_addr.delete(); q_wd.delete();
        e_fail = 0; stop_idx = -1;
        for (int k = 0; k < N; k++) ref_mem[k] = '0;
        for (int e = 0; e < 6; e++) begin
            for (int k = 0; k < N; k++) begin
                int a;
                a = p_down(e) ? (N - 1 - k) : k;
                if (p_reads(e)) begin
                    logic [DW-1:0] ev;
                    ev = pat(chk, a, p_rv(e));
                    push_op(1, 0, a, int'(ev));
                    if (ref_mem[a] != ev && !e_fail) begin
                        e_fail = 1; e_laddr = a; e_lelem = e;
                        e_lrd = int'(ref_mem[a]); e_lexp = int'(ev);
                        stop_idx = q_en.size();
                    end
                end
                if (p_writes(e)) begin
                    push_op(1, 1, a, int'(pat(chk, a, p_wv(e))));
                    ref_mem[a] = faulty(a, pat(chk, a, p_wv(e)));
                end
            end
            if (e < 5) for (int p = 0; p < pause; p++) push_op(0, 0, 0, 0);
        end
        push_op(0, 0, 0, 0);  // last compare cycle
        if (stop && e_fail) while (q_en.size() > stop_idx + 1) begin
            void'(q_en.pop_back()); void'(q_we.pop_back());
            void'(q_addr.pop_back()); void'(q_wd.pop_back());
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // run one test; disturb >= 0 pulses start and flips options at that cycle
    task automatic run(bit chk_mode, int pause, bit stop, string req, int disturb);
        int seen;
        bit ok;
        bg_sel_i = chk_mode; pause_len_i = PW'(pause); stop_on_fail_i = stop;
        build(chk_mode, pause, stop);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(fail_o == 1'b0 && mem_we_o && mem_addr_o == '0, "R1", "clear/first write",
            {fail_o, mem_we_o, 4'(mem_addr_o)}, 6'b010000);
        seen = 0;
        for (int i = 0; i < q_en.size(); i++) begin
            if (i == disturb) begin  // R12 / R11: ignored mid-run
                start_i = 1'b1; bg_sel_i = ~chk_mode;
                pause_len_i = PW'(pause + 2); stop_on_fail_i = ~stop;
            end else if (i == disturb + 1) begin
                start_i = 1'b0; bg_sel_i = chk_mode;
                pause_len_i = PW'(pause); stop_on_fail_i = stop;
            end
            ok = (int'(mem_en_o) == q_en[i]);
            if (q_en[i] != 0) ok = ok && int'(mem_we_o) == q_we[i] && int'(mem_addr_o) == q_addr[i];
            if (q_we[i] != 0) ok = ok && int'(mem_wdata_o) == q_wd[i];
            chk(ok, req, $sformatf("cycle %0d en/we/addr/wd=%0d/%0d/%0h/%0h vs", i,
                mem_en_o, mem_we_o, mem_addr_o, mem_wdata_o),
                (q_en[i] << 24) | (q_we[i] << 16) | (q_addr[i] << 8), q_wd[i]);
            if (mem_en_o) seen++;
            @(negedge clk);
        end
        chk(done_o && !mem_en_o, "R11 R8", "done after last op", {done_o, mem_en_o}, 2'b10);
        if (!(stop && e_fail)) chk(seen == 10 * N, "R2 R9", "enabled cycles", seen, 10 * N);
        chk(fail_o == e_fail, "R7", "fail flag", fail_o, e_fail);
        if (e_fail) begin
            chk(int'(log_addr_o) == e_laddr, "R6", "log addr", log_addr_o, e_laddr);
            chk(int'(log_elem_o) == e_lelem, "R6", "log pass", log_elem_o, e_lelem);
            chk(int'(log_rdata_o) == e_lrd, "R6 R5", "log read", log_rdata_o, e_lrd);
            chk(int'(log_exp_o) == e_lexp, "R6", "log expected", log_exp_o, e_lexp);
        end
    endtask

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !fail_o && !mem_en_o, "R11 R7", "reset state",
            {done_o, fail_o, mem_en_o}, 0);

        // R2 R3: solid, no pause, start and options disturbed mid-run (R12)
        run(1'b0, 0, 1'b0, "R2 R3 R12", 20);
        // R4 R10: checkerboard with retention pause
        run(1'b1, 3, 1'b0, "R4 R10", -1);

        // R9 R6: solid with stuck-at-1 bit 0 at address 5, continue mode
        flt_on = 1; flt_addr = 5; flt_mask = 8'h01; flt_val = 8'h01;
        run(1'b0, 0, 1'b0, "R9 R6", -1);
        repeat (10) @(negedge clk);
        chk(fail_o && done_o, "R7 R11", "held after run", {fail_o, done_o}, 2'b11);

        // R8: checkerboard, stop mode, same fault
        run(1'b1, 0, 1'b1, "R8 R4", -1);

        // R8 R10: solid, stop mode, stuck-at-0 bit 7 at top address, pause 2
        flt_addr = N - 1; flt_mask = 8'h80; flt_val = 8'h00;
        run(1'b0, 2, 1'b1, "R8 R10", -1);

        // R1: clean run after failing runs clears the flag
        flt_on = 0;
        run(1'b0, 1, 1'b0, "R1 R3 R10", -1);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        nchecks++; nfails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

endmodule